// File: doc/BRIEF.md
# I2C Slave With Wake-On-Start

This block is a two-wire serial bus slave with a 7-bit own address, programmed from an input port. It finds start and stop conditions on synchronized copies of SCL and SDA and shifts in the address byte. When the address matches, it acknowledges and then moves data bytes through one byte-wide data register. Software services that register through the data-ready flag in the status byte. Both lines are open drain: the block only asserts pull-low enables and never drives a line high. While software is slow, the block holds SCL low between bytes.

When the host enters a low-power mode (`lowpwr` high), the block drives neither line and leaves its status untouched. A start condition seen while enabled and in low-power mode raises `wake_req`. The address byte after that waking start is always answered with NACK, even when it matches. The bus master is expected to retry after the host is awake. The busy flag lets software check that the bus is idle before it enters low-power mode.

Control state machine, in `i2cw_fsm`:
- IDLE: waits for a start.
- ADDR: shifts in 8 bits. On the SCL fall after the 8th bit it goes to ADDR_ACK on a match, otherwise back to IDLE.
- ADDR_ACK: pulls SDA for the 9th clock. Its closing fall leads to TX_HOLD for a read or RX for a write.
- RX: shifts 8 bits and goes to RX_HOLD on the fall after the 8th bit.
- RX_HOLD: holds SCL and SDA low. It goes to RX_ACK once data-ready clears.
- RX_ACK: keeps SDA low through the 9th clock and returns to RX on its fall.
- TX_HOLD: holds SCL low. It goes to TX once software has written a byte.
- TX: drives 8 bits and goes to TX_ACK on the fall after the 8th bit.
- TX_ACK: samples SDA on the rise. Low leads to TX_NEXT; high leads to IDLE, with the NACK flag set.
- TX_NEXT: goes to TX_HOLD on the fall.

From any state, a start leads to ADDR, a stop leads to IDLE, and deasserting `enable` leads to IDLE.

Top module: `i2cw_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both judged after a two-flop synchronizer. Busy (status bit 2) is set by a start and cleared by a stop seen outside low-power mode.
- R2: The first byte after a start is a 7-bit address, MSB first, followed by a direction bit. If the address equals `own_addr`, SDA is pulled low for the whole 9th clock. Otherwise SDA stays released and the slave ignores the bus until the next start.
- R3: On a match, status bit 0 takes the direction bit: 1 means the slave transmits, 0 means it receives.
- R4: A received byte is assembled MSB first. After its 8th bit it is placed in the data register, data-ready (status bit 1) is set, and SCL is held low. After a read strobe SCL is released and the byte is acknowledged.
- R5: For a read, data-ready is set and SCL is held low until a write strobe supplies the byte. The byte is then sent MSB first, and every master ACK requests the next byte the same way.
- R6: A master NACK after a transmitted byte sets status bit 5, releases SDA and requests no further byte.
- R7: A start seen while `enable` and `lowpwr` are both high sets `wake_req`. It stays high until `lowpwr` or `enable` falls.
- R8: The address byte after a waking start is answered with NACK even when it matches. The next transaction after wake-up is served normally.
- R9: While `lowpwr` is high, neither pull output is asserted and the status byte does not change.
- R10: The status byte is zero after reset and while `enable` is low. A disabled slave pulls no line and never raises `wake_req`.
- R11: Status bit 3 is set by an address match and cleared by a start or stop. Status bit 4 is set by a stop that ends an addressed transfer and cleared by the next match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Slave enable; low clears status and idles the slave |
| lowpwr | input | 1 | Host is in a low-power mode |
| own_addr | input | 7 | Own 7-bit slave address |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1, release when 0 |
| sda_pull | output | 1 | Pull SDA low when 1, release when 0 |
| wake_req | output | 1 | Wake request to the host |
| rd_strobe | input | 1 | Software read of the data register |
| wr_strobe | input | 1 | Software write of the data register |
| wr_data | input | 8 | Byte written by software |
| rd_data | output | 8 | Data register contents |
| status | output | 8 | {2'b0, tx NACK, stopped, addressed, busy, data-ready, transmit} |

## Verification
The following are checked on every clock:
- in low-power mode the pull outputs stay released and the status byte is frozen;
- a disabled slave clears its status and its wake request;
- `wake_req` only rises after a start seen in low-power mode, and falls once the host is awake;
- busy follows start and stop;
- a held SCL is released in the cycle after data-ready clears.

Only the bench's bus scenarios can show the rest:
- the address compare, by a sweep over all 128 addresses;
- the MSB-first order of received and transmitted bytes, by walking-one and walking-zero patterns;
- the NACK of the address after a waking start, followed by the ACK of the retried transaction.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_HOLD,
        ST_RX_ACK,
        ST_TX_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT
    } fsm_state_e;

    localparam int STAT_XMIT  = 0;
    localparam int STAT_DRDY  = 1;
    localparam int STAT_BUSY  = 2;
    localparam int STAT_ADDRD = 3;
    localparam int STAT_SSTOP = 4;
    localparam int STAT_TNACK = 5;
    localparam int STAT_W     = 8;

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < STAGES; g++) begin : stg
        logic [WIDTH-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '1;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '1;
                else        r <= stg[g-1].r;
            end
        end
    end

    assign q = stg[STAGES-1].r;

endmodule

// File: rtl/i2cw_bus_monitor.sv
module i2cw_bus_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic bus_start,
    output logic bus_stop,
    output logic scl_rise,
    output logic scl_fall
);

    logic [1:0] synced;
    logic       scl_s;
    logic       scl_q;
    logic       sda_q;

    i2cw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (synced)
    );

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign bus_start = scl_s && scl_q && sda_q && !sda_s;
    assign bus_stop  = scl_s && scl_q && !sda_q && sda_s;
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;

endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
    import i2cw_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              lowpwr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_s,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              drdy,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              ev_hit,
    output logic              ev_rw,
    output logic              ev_rx_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ev_tx_req,
    output logic              ev_nack
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

    fsm_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [DATA_W-1:0] shreg, shreg_n;
    logic              skip, skip_n;
    logic              advance;

    // the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            skip  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            shreg <= shreg_n;
            skip  <= skip_n;
        end
    end

    // in low-power mode only the address count keeps running
    assign advance = !lowpwr || (state == ST_ADDR);

    // next state, counters and event pulses
    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        shreg_n    = shreg;
        skip_n     = skip;
        ev_hit     = 1'b0;
        ev_rx_done = 1'b0;
        ev_tx_req  = 1'b0;
        ev_nack    = 1'b0;
        if (!enable) begin
            state_n = ST_IDLE;
            skip_n  = 1'b0;
        end else if (bus_start) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
            skip_n  = lowpwr;
        end else if (bus_stop) begin
            state_n = ST_IDLE;
        end else if (advance) begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_RX: begin
                    if (scl_rise && cnt != CNT_FULL) begin
                        shreg_n = {shreg[DATA_W-2:0], sda_s};
                        cnt_n   = cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_FULL) begin
                        if (state == ST_RX) begin
                            state_n    = ST_RX_HOLD;
                            ev_rx_done = 1'b1;
                        end else if (shreg[DATA_W-1:1] == own_addr && !skip && !lowpwr) begin
                            state_n = ST_ADDR_ACK;
                            ev_hit  = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (shreg[0]) begin
                            state_n   = ST_TX_HOLD;
                            ev_tx_req = 1'b1;
                        end else begin
                            state_n = ST_RX;
                            cnt_n   = '0;
                        end
                    end
                end
                ST_RX_HOLD: begin
                    if (!drdy) state_n = ST_RX_ACK;
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        state_n = ST_RX;
                        cnt_n   = '0;
                    end
                end
                ST_TX_HOLD: begin
                    if (!drdy) begin
                        state_n = ST_TX;
                        shreg_n = tx_byte;
                        cnt_n   = '0;
                    end
                end
                ST_TX: begin
                    if (scl_rise && cnt != CNT_FULL) begin
                        cnt_n = cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == CNT_FULL) state_n = ST_TX_ACK;
                        else                 shreg_n = {shreg[DATA_W-2:0], 1'b0};
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            state_n = ST_TX_NEXT;
                        end else begin
                            state_n = ST_IDLE;
                            ev_nack = 1'b1;
                        end
                    end
                end
                ST_TX_NEXT: begin
                    if (scl_fall) begin
                        state_n   = ST_TX_HOLD;
                        ev_tx_req = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // line outputs, released whenever disabled or in low-power mode
    always_comb begin
        logic scl_d;
        logic sda_d;
        scl_d = (state == ST_RX_HOLD) || (state == ST_TX_HOLD);
        sda_d = (state == ST_ADDR_ACK) || (state == ST_RX_HOLD) || (state == ST_RX_ACK)
             || ((state == ST_TX_HOLD) && !drdy && !tx_byte[DATA_W-1])
             || ((state == ST_TX) && !shreg[DATA_W-1]);
        scl_pull = scl_d && enable && !lowpwr;
        sda_pull = sda_d && enable && !lowpwr;
    end

    assign ev_rw   = shreg[0];
    assign rx_byte = shreg;

endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
    import i2cw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              lowpwr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              wake_req,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] status
);

    logic              sda_s;
    logic              bus_start;
    logic              bus_stop;
    logic              scl_rise;
    logic              scl_fall;
    logic              ev_hit;
    logic              ev_rw;
    logic              ev_rx_done;
    logic              ev_tx_req;
    logic              ev_nack;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] data_reg;
    logic              st_xmit;
    logic              st_drdy;
    logic              st_busy;
    logic              st_addrd;
    logic              st_sstop;
    logic              st_tnack;
    logic              sw_take;

    i2cw_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2cw_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .lowpwr     (lowpwr),
        .own_addr   (own_addr),
        .sda_s      (sda_s),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .drdy       (st_drdy),
        .tx_byte    (data_reg),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .ev_hit     (ev_hit),
        .ev_rw      (ev_rw),
        .ev_rx_done (ev_rx_done),
        .rx_byte    (rx_byte),
        .ev_tx_req  (ev_tx_req),
        .ev_nack    (ev_nack)
    );

    // software access is honoured only while data-ready is set
    assign sw_take = st_drdy && ((rd_strobe && !st_xmit) || (wr_strobe && st_xmit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_reg <= '0;
            wake_req <= 1'b0;
            st_xmit  <= 1'b0;
            st_drdy  <= 1'b0;
            st_busy  <= 1'b0;
            st_addrd <= 1'b0;
            st_sstop <= 1'b0;
            st_tnack <= 1'b0;
        end else if (!enable) begin
            wake_req <= 1'b0;
            st_xmit  <= 1'b0;
            st_drdy  <= 1'b0;
            st_busy  <= 1'b0;
            st_addrd <= 1'b0;
            st_sstop <= 1'b0;
            st_tnack <= 1'b0;
        end else begin
            wake_req <= lowpwr && (wake_req || bus_start);
            if (!lowpwr) begin
                if (bus_start) begin
                    st_busy  <= 1'b1;
                    st_addrd <= 1'b0;
                    st_xmit  <= 1'b0;
                    st_drdy  <= 1'b0;
                end else if (bus_stop) begin
                    st_busy  <= 1'b0;
                    st_sstop <= st_sstop || st_addrd;
                    st_addrd <= 1'b0;
                    st_xmit  <= 1'b0;
                    st_drdy  <= 1'b0;
                end
                if (ev_hit) begin
                    st_addrd <= 1'b1;
                    st_xmit  <= ev_rw;
                    st_sstop <= 1'b0;
                    st_tnack <= 1'b0;
                end
                if (ev_rx_done) begin
                    data_reg <= rx_byte;
                    st_drdy  <= 1'b1;
                end
                if (ev_tx_req) st_drdy  <= 1'b1;
                if (ev_nack)   st_tnack <= 1'b1;
                if (sw_take) begin
                    st_drdy <= 1'b0;
                    if (st_xmit) data_reg <= wr_data;
                end
            end
        end
    end

    assign rd_data = data_reg;
    assign status  = {2'b00, st_tnack, st_sstop, st_addrd, st_busy, st_drdy, st_xmit};

endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       lowpwr,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       wake_req,
    input logic [7:0] status
);

    assert_lowpwr_no_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr |-> (!scl_pull && !sda_pull));

    assert_lowpwr_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && lowpwr) |=> (status == $past(status)));

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (status == 8'h00 && !wake_req));

    assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(lowpwr && bus_start));

    assert_wake_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lowpwr |=> !wake_req);

    assert_busy_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !lowpwr && bus_start) |=> status[2]);

    assert_busy_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !lowpwr && bus_stop && !bus_start) |=> !status[2]);

    // R5 shares this rule for the transmit hold
    assert_stretch_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && !status[1]) |=> !scl_pull);

endmodule

bind i2cw_slave i2cw_slave_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .lowpwr    (lowpwr),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .wake_req  (wake_req),
    .status    (status)
);

// File: tb/i2cw_slave_tb_top.sv
`timescale 1ns/1ps
module i2cw_slave_tb_top;

    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       lowpwr = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scl_pull, sda_pull, wake_req;
    logic [7:0] rd_data, status;
    logic       scl_line, sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int rx_n = 0;
    int tx_n = 0;
    logic [7:0] rx_got [64];

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    i2cw_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .lowpwr    (lowpwr),
        .own_addr  (OWN),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .wake_req  (wake_req),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .status    (status)
    );

    function automatic logic [7:0] pat(int k);
        if (k < 8)       return 8'(1 << k);
        else if (k < 16) return ~8'(1 << (k - 8));
        else             return 8'((k * 73 + 11) & 255);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // software agent: services data-ready
    initial begin
        forever begin
            @(negedge clk);
            if (enable && !lowpwr && status[1]) begin
                if (status[0]) begin
                    wr_data   = pat(tx_n + 3);
                    tx_n++;
                    wr_strobe = 1'b1;
                    @(negedge clk);
                    wr_strobe = 1'b0;
                end else begin
                    if (rx_n < 64) rx_got[rx_n] = rd_data;
                    rx_n++;
                    rd_strobe = 1'b1;
                    @(negedge clk);
                    rd_strobe = 1'b0;
                end
            end
        end
    end

    task automatic hw(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; hw(H);
        scl_m = 1'b1; wait_scl_high(); hw(H);
        sda_m = 1'b0; hw(H);
        scl_m = 1'b0; hw(H);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hw(H);
        scl_m = 1'b1; wait_scl_high(); hw(H);
        sda_m = 1'b1; hw(H);
    endtask

    task automatic m_bit_w(bit b);
        sda_m = b; hw(H);
        scl_m = 1'b1; wait_scl_high(); hw(H);
        scl_m = 1'b0; hw(4);
    endtask

    task automatic m_bit_r(output bit b);
        sda_m = 1'b1; hw(H);
        scl_m = 1'b1; wait_scl_high(); hw(H / 2);
        b = sda_line; hw(H / 2);
        scl_m = 1'b0; hw(4);
    endtask

    task automatic m_byte_w(logic [7:0] v, output bit nak);
        for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
        m_bit_r(nak);
    endtask

    task automatic m_byte_r(output logic [7:0] v, input bit nak);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_r(b);
            v[i] = b;
        end
        m_bit_w(nak);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        bit nak;
        logic [7:0] v;
        logic [7:0] snap;

        hw(10);
        // R10: reset state
        check(status == 8'h00, "R10 reset status", status, 0);
        check(!wake_req && !scl_pull && !sda_pull, "R10 reset outputs",
              {wake_req, scl_pull, sda_pull}, 0);
        rst_n = 1'b1;
        hw(4);
        enable = 1'b1;
        hw(4);

        // write transfer, byte order sweep
        m_start();
        check(status[2] == 1'b1, "R1 busy after start", status[2], 1);
        m_byte_w({OWN, 1'b0}, nak);
        check(nak == 1'b0, "R2 own address acked", nak, 0);
        check(status[0] == 1'b0, "R3 receive direction", status[0], 0);
        check(status[3] == 1'b1, "R11 addressed flag", status[3], 1);
        for (int k = 0; k < 64; k++) begin
            m_byte_w(pat(k), nak);
            check(nak == 1'b0, "R4 data byte acked", nak, 0);
        end
        m_stop();
        check(status[2] == 1'b0, "R1 busy cleared by stop", status[2], 1'b0);
        check(status[4] == 1'b1 && status[3] == 1'b0, "R11 stop flags",
              status[4:3], 2'b10);
        check(rx_n == 64, "R4 bytes delivered", rx_n, 64);
        for (int k = 0; k < 64; k++)
            check(rx_got[k] == pat(k), "R4 received byte MSB first", rx_got[k], pat(k));

        // R2: exhaustive address sweep
        for (int a = 0; a < 128; a++) begin
            m_start();
            m_byte_w({7'(a), 1'b0}, nak);
            check(nak == (7'(a) != OWN), "R2 address compare", nak, (7'(a) != OWN));
            m_stop();
        end

        // read transfer
        tx_n = 0;
        m_start();
        m_byte_w({OWN, 1'b1}, nak);
        check(nak == 1'b0, "R2 read address acked", nak, 0);
        check(status[0] == 1'b1, "R3 transmit direction", status[0], 1);
        for (int k = 0; k < 32; k++) begin
            m_byte_r(v, (k == 31));
            check(v == pat(k + 3), "R5 transmitted byte MSB first", v, pat(k + 3));
        end
        hw(8);
        check(status[5] == 1'b1, "R6 NACK flag", status[5], 1);
        check(sda_pull == 1'b0 && scl_pull == 1'b0, "R6 lines released",
              {scl_pull, sda_pull}, 0);
        check(tx_n == 32 && status[1] == 1'b0, "R6 no further request", tx_n, 32);
        m_stop();

        // wake-up: lowpwr drops during the address
        snap = status;
        lowpwr = 1'b1;
        hw(4);
        m_start();
        check(wake_req == 1'b1, "R7 wake on start", wake_req, 1);
        check(status == snap, "R9 status kept in low power", status, snap);
        for (int i = 7; i >= 4; i--) m_bit_w(OWN[i - 1]);
        check(!scl_pull && !sda_pull, "R9 no pulls in low power", {scl_pull, sda_pull}, 0);
        check(status == snap, "R9 status kept during address", status, snap);
        lowpwr = 1'b0;
        hw(3);
        check(wake_req == 1'b0, "R7 wake drops when awake", wake_req, 0);
        for (int i = 3; i >= 1; i--) m_bit_w(OWN[i - 1]);
        m_bit_w(1'b0);
        m_bit_r(nak);
        check(nak == 1'b1, "R8 waking address NACKed", nak, 1);
        m_stop();
        rx_n = 0;
        m_start();
        m_byte_w({OWN, 1'b0}, nak);
        check(nak == 1'b0, "R8 retry acked", nak, 0);
        m_byte_w(8'h5A, nak);
        m_stop();
        check(rx_n == 1 && rx_got[0] == 8'h5A, "R8 retry data", rx_got[0], 8'h5A);

        // whole address while still in low power
        lowpwr = 1'b1;
        hw(4);
        m_start();
        m_byte_w({OWN, 1'b0}, nak);
        check(nak == 1'b1, "R9 no ACK while asleep", nak, 1);
        lowpwr = 1'b0;
        m_stop();

        // disabled slave
        enable = 1'b0;
        hw(4);
        check(status == 8'h00, "R10 cleared by disable", status, 0);
        lowpwr = 1'b1;
        m_start();
        check(wake_req == 1'b0, "R10 no wake when disabled", wake_req, 0);
        m_byte_w({OWN, 1'b0}, nak);
        check(nak == 1'b1, "R10 disabled slave silent", nak, 1);
        m_stop();
        lowpwr = 1'b0;
        enable = 1'b1;
        hw(4);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule